// File: doc/BRIEF.md
# Flash self-programming command controller

This block sits between a CPU and an on-chip flash whose address space is split into a read-while-write region (low addresses) and a no-read-while-write region (addresses at or above a parameter boundary). Software writes a one-byte control register to arm a command. The command takes effect only if the matching strobe follows within a short window. A store strobe launches a page erase, a page write, a page-buffer fill, a lock-bit write or a re-enable of the read-while-write region. A load strobe returns a lock or fuse byte instead of flash data. An armed command that sees no strobe in time is dropped without any action.

Erase, page write and lock write each run for a fixed number of clock cycles, set by a parameter. The enable bit stays set for that whole time. A busy flag marks the read-while-write region as unreadable from the start of an erase or page write. It stays set until software issues the re-enable command. The block halts the CPU while an erase or page write targets the no-read-while-write region. A level interrupt is raised whenever the enable bit is clear and interrupts are enabled.

The control is one state machine with three states. IDLE: nothing is armed. ARMED: a command waits for its strobe. PROG: a timed operation runs. The transitions are:
- arm: IDLE to ARMED;
- re-arm: ARMED to ARMED on a new register write;
- launch: ARMED to PROG on a store strobe for erase, page write or lock write;
- quick-done: ARMED to IDLE on a store strobe for fill or re-enable, or on a served load strobe;
- lapse: ARMED to IDLE when the window runs out;
- finish: PROG to IDLE when the timer expires.

Top module: `selfprog_ctrl`

## Requirements
- R1: Control register layout, as read on `reg_rdata`: bit0 enable, bit1 erase, bit2 page write, bit3 lock set, bit4 re-enable, bit5 reads 0, bit6 busy, bit7 interrupt enable. Bit6 is read-only and written values there are ignored. Bits 4:0 read 0 whenever no command is armed or running. The register reads 0x00 after reset.
- R2: A write with bit0 set arms the command in bits 4:1. A store strobe is accepted on the first through fourth clock edge after the write edge. If no strobe arrives by the fourth edge, the command lapses, bit0 clears, and later strobes do nothing.
- R3: Pattern 0x05 followed by a store strobe produces a one-cycle `fl_write` pulse, registered on the strobe edge, with `fl_addr` equal to `ptr`. Bit0 then stays set for exactly PROG_CYCLES cycles.
- R4: Pattern 0x03 behaves like R3 but pulses `fl_erase`. Pattern 0x01 pulses `fl_fill` with `fl_wdata` equal to `store_data`, and bit0 clears on the same edge. At most one of the three flash pulses is high at any time.
- R5: Pattern 0x09 followed by a store strobe is a lock write, and `ptr` is ignored. When the operation ends, each lock bit 5:2 whose `store_data` bit 5:2 is 0 becomes programmed (0). A 1 never returns a bit to the unprogrammed state.
- R6: With pattern 0x09 armed, a load strobe on the first through third edge asserts `load_hit` in that same cycle. `load_data` is selected by `ptr`: 0x0000 gives `fuse_lo`, 0x0001 gives {2'b11, lock bits 5:0}, 0x0003 gives `fuse_hi`, any other value gives 0xFF. Bit0 then clears. A load strobe on the fourth edge is not served.
- R7: `rww_busy` (register bit6) sets on the accepted strobe of an erase or page write. It stays set after the operation ends, and clears only on a store strobe for pattern 0x11.
- R8: `cpu_halt` is high for the whole duration of an erase or page write whose `ptr` is at or above NRWW_BASE. It stays low for lower addresses and for lock writes.
- R9: `irq` is high whenever bit7 is set and bit0 is clear, as a level, and is low otherwise.
- R10: While `ee_busy` is high, register writes with bit0 set arm nothing, though bit7 is still updated, and load strobes are not served.
- R11: While an operation runs, register writes change only bit7. Store strobes produce no flash pulse.
- R12: A write that sets more than one of bits 4:1 arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| store_stb | input | 1 | Store instruction strobe |
| load_stb | input | 1 | Load instruction strobe |
| ptr | input | PTR_W | Address pointer |
| store_data | input | 16 | Data word for fill and lock write |
| ee_busy | input | 1 | EEPROM write in progress |
| fuse_lo | input | 8 | Low fuse byte |
| fuse_hi | input | 8 | High fuse byte |
| load_hit | output | 1 | Load strobe served by this block |
| load_data | output | 8 | Lock or fuse byte on a served load |
| fl_erase | output | 1 | Page erase pulse to flash |
| fl_write | output | 1 | Page write pulse to flash |
| fl_fill | output | 1 | Page buffer fill pulse to flash |
| fl_addr | output | PTR_W | Address for the flash pulse |
| fl_wdata | output | 16 | Fill data for the flash pulse |
| rww_busy | output | 1 | Read-while-write region blocked |
| cpu_halt | output | 1 | CPU stall request |
| irq | output | 1 | Level interrupt |

## Verification
The strobe delay is swept from one to six cycles after the register write for fill, erase and page write. This separates the fourth edge, where the strobe is still accepted, from the fifth, where the command has already lapsed. All sixteen lock data nibbles are written twice in a row. The second readback must equal the bitwise AND of the two nibbles, which shows the lock bits only ever move toward programmed. Load readback is swept over eight pointer values and four delays, which covers each selected byte, the 0xFF fallback, and the three-cycle load limit against the four-cycle store limit. Pointers on both sides of the region boundary tell a halted page write from one that lets the CPU run.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PROG
    } sp_state_e;

    localparam int CB_EN    = 0;
    localparam int CB_ERASE = 1;
    localparam int CB_WRITE = 2;
    localparam int CB_LOCK  = 3;
    localparam int CB_RWWEN = 4;
    localparam int CB_BUSY  = 6;
    localparam int CB_IE    = 7;

    // at most one command bit set in a 4-bit field
    function automatic logic at_most_one(input logic [3:0] v);
        return (v & (v - 4'd1)) == 4'd0;
    endfunction

endpackage

// File: rtl/selfprog_window.sv
module selfprog_window #(
    parameter int STORE_WIN = 4,
    parameter int LOAD_WIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic load_ok,
    output logic expire
);
    localparam int CW = $clog2(STORE_WIN + 1);
    localparam logic [CW-1:0] LAST = CW'(STORE_WIN - 1);

    logic [CW-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (start) begin
            age_q <= '0;
        end else if (run && age_q != LAST) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign load_ok = age_q < CW'(LOAD_WIN);
    assign expire  = age_q == LAST;

    AST_WINDOW_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (load_ok && !expire)); // R2

endmodule

// File: rtl/selfprog_timer.sv
module selfprog_timer #(
    parameter int PROG_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = run_q;
    assign done = run_q && (cnt_q == LAST);

    AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy); // R3

endmodule

// File: rtl/selfprog_lockbank.sv
module selfprog_lockbank #(
    parameter int         PTR_W     = 16,
    parameter logic [5:0] LOCK_INIT = 6'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic [3:0]       new_bits,
    input  logic [PTR_W-1:0] ptr,
    input  logic [7:0]       fuse_lo,
    input  logic [7:0]       fuse_hi,
    output logic [7:0]       rd_byte
);
    logic [5:0] lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= LOCK_INIT;
        end else if (apply) begin
            lock_q <= lock_q & {new_bits, 2'b11};
        end
    end

    always_comb begin
        if (ptr == PTR_W'(0)) begin
            rd_byte = fuse_lo;
        end else if (ptr == PTR_W'(1)) begin
            rd_byte = {2'b11, lock_q};
        end else if (ptr == PTR_W'(3)) begin
            rd_byte = fuse_hi;
        end else begin
            rd_byte = 8'hFF;
        end
    end

    AST_LOCK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        (~$past(lock_q) & lock_q) == 6'b0); // R5

endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int          PTR_W       = 16,
    parameter int          PROG_CYCLES = 200000,
    parameter int unsigned NRWW_BASE   = 'h1C00,
    parameter int          STORE_WIN   = 4,
    parameter int          LOAD_WIN    = 3,
    parameter logic [5:0]  LOCK_INIT   = 6'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             store_stb,
    input  logic             load_stb,
    input  logic [PTR_W-1:0] ptr,
    input  logic [15:0]      store_data,
    input  logic             ee_busy,
    input  logic [7:0]       fuse_lo,
    input  logic [7:0]       fuse_hi,
    output logic             load_hit,
    output logic [7:0]       load_data,
    output logic             fl_erase,
    output logic             fl_write,
    output logic             fl_fill,
    output logic [PTR_W-1:0] fl_addr,
    output logic [15:0]      fl_wdata,
    output logic             rww_busy,
    output logic             cpu_halt,
    output logic             irq
);
    localparam logic [PTR_W-1:0] BOUNDARY = PTR_W'(NRWW_BASE);

    sp_state_e  state_q, state_d;
    logic [3:0] cmd_q;
    logic [3:0] lockdat_q;
    logic       ie_q, busy_q, halt_tgt_q;

    logic [3:0] wcmd;
    logic       arm_ok, armed, st_acc, ld_acc, st_long, en;
    logic       win_load_ok, win_expire;
    logic       tmr_busy, tmr_done;
    logic [7:0] rd_byte;
    logic       unused_bits;

    assign unused_bits = ^reg_wdata[6:5];

    assign wcmd    = reg_wdata[CB_RWWEN:CB_ERASE];
    assign arm_ok  = reg_we && reg_wdata[CB_EN] && !ee_busy
                     && (state_q != ST_PROG) && at_most_one(wcmd);
    assign armed   = state_q == ST_ARMED;
    assign st_acc  = armed && !arm_ok && store_stb;
    assign ld_acc  = armed && !arm_ok && !store_stb && load_stb
                     && cmd_q[2] && win_load_ok && !ee_busy;
    assign st_long = st_acc && (cmd_q[0] || cmd_q[1] || cmd_q[2]);
    assign en      = state_q != ST_IDLE;

    selfprog_window #(
        .STORE_WIN (STORE_WIN),
        .LOAD_WIN  (LOAD_WIN)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (arm_ok),
        .run     (armed),
        .load_ok (win_load_ok),
        .expire  (win_expire)
    );

    selfprog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_long),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    selfprog_lockbank #(
        .PTR_W     (PTR_W),
        .LOCK_INIT (LOCK_INIT)
    ) u_lockbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (tmr_done && cmd_q[2]),
        .new_bits (lockdat_q),
        .ptr      (ptr),
        .fuse_lo  (fuse_lo),
        .fuse_hi  (fuse_hi),
        .rd_byte  (rd_byte)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_ok) state_d = ST_ARMED;           // arm
            end
            ST_ARMED: begin
                if (arm_ok)          state_d = ST_ARMED;  // re-arm
                else if (st_long)    state_d = ST_PROG;   // launch
                else if (st_acc)     state_d = ST_IDLE;   // quick-done
                else if (ld_acc)     state_d = ST_IDLE;   // quick-done
                else if (win_expire) state_d = ST_IDLE;   // lapse
            end
            ST_PROG: begin
                if (tmr_done) state_d = ST_IDLE;          // finish
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            lockdat_q  <= '0;
            ie_q       <= 1'b0;
            busy_q     <= 1'b0;
            halt_tgt_q <= 1'b0;
            fl_erase   <= 1'b0;
            fl_write   <= 1'b0;
            fl_fill    <= 1'b0;
            fl_addr    <= '0;
            fl_wdata   <= '0;
        end else begin
            fl_erase <= 1'b0;
            fl_write <= 1'b0;
            fl_fill  <= 1'b0;
            if (reg_we) ie_q <= reg_wdata[CB_IE];
            if (arm_ok) cmd_q <= wcmd;
            if (st_acc) begin
                fl_erase   <= cmd_q[0];
                fl_write   <= cmd_q[1];
                fl_fill    <= cmd_q == 4'b0000;
                fl_addr    <= ptr;
                fl_wdata   <= store_data;
                lockdat_q  <= store_data[5:2];
                halt_tgt_q <= (cmd_q[0] || cmd_q[1]) && (ptr >= BOUNDARY);
                if (cmd_q[0] || cmd_q[1]) busy_q <= 1'b1;
                if (cmd_q[3])             busy_q <= 1'b0;
            end
        end
    end

    assign reg_rdata = {ie_q, busy_q, 1'b0, (en ? cmd_q : 4'b0000), en};
    assign rww_busy  = busy_q;
    assign cpu_halt  = (state_q == ST_PROG) && halt_tgt_q;
    assign irq       = ie_q && !en;
    assign load_hit  = ld_acc;
    assign load_data = ld_acc ? rd_byte : 8'h00;

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_erase, fl_write, fl_fill})); // R4
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_erase || fl_write || fl_fill) |-> $past(store_stb)); // R2
    AST_HALT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> rww_busy); // R8
    AST_PROG_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> tmr_busy); // R3
    AST_EE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ee_busy) |=> (state_q != ST_ARMED)); // R10
    AST_PROG_FREEZES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) == ST_PROG) |-> $stable(cmd_q)); // R11

endmodule

// File: tb/tb_selfprog_ctrl.sv
`timescale 1ns/1ps
module tb_selfprog_ctrl;
    localparam int P    = 12;
    localparam int BASE = 'h1C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        store_stb = 1'b0;
    logic        load_stb = 1'b0;
    logic [15:0] ptr = '0;
    logic [15:0] store_data = '0;
    logic        ee_busy = 1'b0;
    logic [7:0]  fuse_lo = 8'hA5;
    logic [7:0]  fuse_hi = 8'h3C;
    logic        load_hit;
    logic [7:0]  load_data;
    logic        fl_erase, fl_write, fl_fill;
    logic [15:0] fl_addr;
    logic [15:0] fl_wdata;
    logic        rww_busy, cpu_halt, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    selfprog_ctrl #(
        .PTR_W       (16),
        .PROG_CYCLES (P),
        .NRWW_BASE   (BASE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .store_stb(store_stb), .load_stb(load_stb),
        .ptr(ptr), .store_data(store_data), .ee_busy(ee_busy),
        .fuse_lo(fuse_lo), .fuse_hi(fuse_hi), .load_hit(load_hit),
        .load_data(load_data), .fl_erase(fl_erase), .fl_write(fl_write),
        .fl_fill(fl_fill), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .rww_busy(rww_busy), .cpu_halt(cpu_halt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_we = 1'b0; store_stb = 1'b0; load_stb = 1'b0; ee_busy = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic st(input int age);
        repeat (age - 1) @(negedge clk);
        store_stb = 1'b1;
        @(negedge clk);
        store_stb = 1'b0;
    endtask

    task automatic ld(input int age, output logic hit, output logic [7:0] data);
        repeat (age - 1) @(negedge clk);
        load_stb = 1'b1;
        #1;
        hit = load_hit; data = load_data;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    function automatic logic [7:0] rb_exp(input int p, input logic [3:0] lk);
        if (p == 0) return 8'hA5;
        if (p == 1) return {2'b11, lk, 2'b11};
        if (p == 3) return 8'h3C;
        return 8'hFF;
    endfunction

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL WATCHDOG actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       h;
        logic [7:0] d;
        logic [7:0] ops [3];
        ops[0] = 8'h01; ops[1] = 8'h03; ops[2] = 8'h05;

        do_reset();
        check("R1 reset rdata", reg_rdata, 8'h00);
        check("R9 reset irq", irq, 0);
        check("R7 reset busy", rww_busy, 0);
        check("R8 reset halt", cpu_halt, 0);
        check("R6 reset load_hit", load_hit, 0);

        // R1: busy bit read-only, layout
        wr(8'hC5);
        check("R1 armed layout", reg_rdata, 8'h85);
        repeat (5) @(negedge clk);
        check("R1 lapsed layout", reg_rdata, 8'h80);
        check("R9 irq level", irq, 1);
        wr(8'h00);
        check("R9 irq off", irq, 0);

        // R2/R3/R4: store delay sweep
        for (int oi = 0; oi < 3; oi++) begin
            for (int age = 1; age <= 6; age++) begin
                logic       acc;
                logic [2:0] pat;
                do_reset();
                ptr = 16'h0040;
                store_data = 16'h1230 + 16'(age);
                pat = {ops[oi][1], ops[oi][2], ops[oi] == 8'h01};
                wr(ops[oi]);
                st(age);
                acc = age <= 4;
                check("R2 pulse vs delay", {fl_erase, fl_write, fl_fill}, acc ? pat : 3'b000);
                check("R2 enable after strobe", reg_rdata[0], acc && ops[oi] != 8'h01);
                if (acc) begin
                    check("R3 fl_addr", fl_addr, 16'h0040);
                    if (ops[oi] == 8'h01) check("R4 fill data", fl_wdata, 16'h1230 + 16'(age));
                end
                if (acc && ops[oi] != 8'h01) begin
                    @(negedge clk);
                    check("R4 pulse one cycle", {fl_erase, fl_write, fl_fill}, 3'b000);
                    check("R7 busy set", rww_busy, 1);
                    repeat (P - 2) @(negedge clk);
                    check("R3 enable held", reg_rdata[0], 1);
                    @(negedge clk);
                    check("R3 enable cleared", reg_rdata[0], 0);
                    check("R7 busy persists", rww_busy, 1);
                    wr(8'h11);
                    st(1);
                    check("R7 busy cleared", rww_busy, 0);
                end
            end
        end

        // R8: halt vs region
        for (int k = 0; k < 4; k++) begin
            logic [15:0] pv;
            pv = (k == 0) ? 16'h0000 : (k == 1) ? 16'(BASE - 1) : (k == 2) ? 16'(BASE) : 16'hFFFF;
            for (int oi = 1; oi < 3; oi++) begin
                do_reset();
                ptr = pv;
                wr(ops[oi]);
                st(1);
                check("R8 halt during op", cpu_halt, pv >= 16'(BASE));
                repeat (P) @(negedge clk);
                check("R8 halt after op", cpu_halt, 0);
            end
        end
        do_reset();
        ptr = 16'hFFFF;
        wr(8'h09);
        st(1);
        check("R8 no halt on lock write", cpu_halt, 0);
        repeat (P) @(negedge clk);

        // R11: writes during programming
        do_reset();
        ptr = 16'h0100;
        wr(8'h05);
        st(1);
        wr(8'h83);
        check("R11 only ie changes", reg_rdata, 8'hC5);
        st(1);
        check("R11 no pulse while busy", {fl_erase, fl_write, fl_fill}, 3'b000);
        repeat (P) @(negedge clk);

        // R5/R6: lock nibble sweep, two writes each
        for (int v = 0; v < 16; v++) begin
            logic [3:0] w;
            w = 4'((v * 7 + 3) & 15);
            do_reset();
            ptr = 16'h1234;
            store_data = {8'h00, 2'b11, 4'(v), 2'b11};
            wr(8'h09);
            st(1);
            repeat (P) @(negedge clk);
            ptr = 16'h0001;
            wr(8'h09);
            ld(1, h, d);
            check("R5 lock first", {h, d}, {1'b1, 2'b11, 4'(v), 2'b11});
            check("R6 enable clears after read", reg_rdata[0], 0);
            store_data = {8'h00, 2'b11, w, 2'b11};
            wr(8'h09);
            st(1);
            repeat (P) @(negedge clk);
            wr(8'h09);
            ld(1, h, d);
            check("R5 lock one-way", {h, d}, {1'b1, 2'b11, 4'(v) & w, 2'b11});
        end

        // R6: pointer and load delay sweep
        do_reset();
        store_data = 16'h0000;
        wr(8'h09);
        st(1);
        repeat (P) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            for (int age = 1; age <= 4; age++) begin
                ptr = 16'(p);
                wr(8'h09);
                ld(age, h, d);
                check("R6 readback", {h, d}, (age <= 3) ? {1'b1, rb_exp(p, 4'h0)} : 9'h000);
                @(negedge clk);
                check("R6 idle after", reg_rdata[0], 0);
            end
        end

        // R10: EEPROM busy
        do_reset();
        ee_busy = 1'b1;
        wr(8'h85);
        check("R10 no arm, ie kept", reg_rdata, 8'h80);
        st(1);
        check("R10 no pulse", {fl_erase, fl_write, fl_fill}, 3'b000);
        ee_busy = 1'b0;
        ptr = 16'h0001;
        wr(8'h09);
        ee_busy = 1'b1;
        ld(1, h, d);
        check("R10 readback blocked", h, 0);
        ee_busy = 1'b0;
        repeat (4) @(negedge clk);

        // R12: invalid patterns
        do_reset();
        wr(8'h07);
        check("R12 two bits ignored", reg_rdata, 8'h00);
        st(1);
        check("R12 no pulse", {fl_erase, fl_write, fl_fill}, 3'b000);
        wr(8'h19);
        check("R12 lock+rww ignored", reg_rdata, 8'h00);

        // R9: irq across an operation
        do_reset();
        wr(8'h80);
        check("R9 irq on", irq, 1);
        wr(8'h85);
        check("R9 irq low when armed", irq, 0);
        st(1);
        check("R9 irq low while running", irq, 0);
        repeat (P) @(negedge clk);
        check("R9 irq back after finish", irq, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule